// File: doc/BRIEF.md
# Receive Frame Accept Filter

This block sits behind preamble and start-delimiter removal in an Ethernet receive path. It takes the stripped byte stream of one frame at a time, marked by start and end flags, and counts its bytes. After the six destination-address bytes it checks the destination address. It then tells the receive FIFO whether to keep or drop the frame. The verdict waits until the 64-byte collision window is complete. Fragments cut short by a collision are therefore dropped without notice, and frames hit by a collision later than that are still delivered.

While the frame runs, the block watches for frames that exceed the programmed maximum length. Such a frame is never cut short. The block raises a babble interrupt and marks the frame as long. The CRC check is done elsewhere, and its result arrives with the last byte. When an accepted frame ends, the block writes a 32-bit status word for it and can raise a frame-received interrupt.

Top module: `rx_accept_filter`

## Requirements
- R1: While reset is held, and in the first cycle after it, `fifo_accept`, `fifo_reject`, `stat_wr`, `stat_word`, `babr_irq` and `rfint_irq` are all zero.
- R2: Received bytes 1 to 6 form the destination address. Byte k (1-based) is compared with `station_addr[8*(k-1)+7 : 8*(k-1)]`. The address passes if all six bytes equal the station address, if all six are 8'hFF, or if `promisc` is high.
- R3: If no reject has been issued for a frame, `fifo_accept` pulses for one cycle. The pulse comes in the cycle after the cycle that delivers byte 64.
- R4: If the address fails, `fifo_reject` pulses in the cycle after byte 6.
- R5: A `coll` seen during a frame while fewer than 64 bytes have arrived gives a `fifo_reject` pulse in the next cycle. `coll` outside a frame has no effect.
- R6: A frame whose end byte is one of its first 63 bytes gets a `fifo_reject` pulse in the cycle after that end byte.
- R7: Each frame receives at most one decision pulse, either accept or reject, never both and never repeated.
- R8: A `coll` seen once 64 or more bytes have arrived causes no reject. It sets status bit 18 of that frame.
- R9: When a frame's byte count first exceeds `max_len`, `babr_irq` pulses once in the next cycle. Reception of the frame continues. Its length field holds the full count and status bit 16 is set.
- R10: `stat_wr` pulses one cycle after the end byte of an accepted frame, and only for accepted frames. `stat_word[15:0]` is the byte count, saturating at 16'hFFFF. Bit 16 is the long flag. Bit 17 is `crc_err` sampled with the end byte. Bit 18 is the late-collision flag. Bit 19 is set when the address matched neither the station nor broadcast and the frame was admitted through `promisc`. Bits 31:20 are zero.
- R11: `rfint_irq` pulses together with `stat_wr` when `rfint_en` is high. It stays low when `rfint_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_vld | input | 1 | A byte is present on `byte_data` |
| byte_sof | input | 1 | With `byte_vld`: first byte of a frame |
| byte_eof | input | 1 | With `byte_vld`: last byte of a frame |
| byte_data | input | 8 | Received byte |
| coll | input | 1 | Collision indication |
| crc_err | input | 1 | CRC error flag, valid with the end byte |
| station_addr | input | 48 | Station address, byte 1 in bits 7:0 |
| max_len | input | 16 | Maximum frame length in bytes |
| promisc | input | 1 | Accept every destination address |
| rfint_en | input | 1 | Frame-received interrupt enable |
| fifo_accept | output | 1 | Accept command to the receive FIFO |
| fifo_reject | output | 1 | Reject command to the receive FIFO |
| stat_wr | output | 1 | Status word write strobe |
| stat_word | output | 32 | Frame status word |
| babr_irq | output | 1 | Babbling-receive interrupt pulse |
| rfint_irq | output | 1 | Frame-received interrupt pulse |

## Verification
A byte counter that is off by one moves the accept pulse a cycle away from byte 64. It also moves the reject pulse a cycle away from byte 6, and both show one cycle after the faulty count. Address-match state that carries over from an earlier frame shows as a wrong decision right after byte 6. A sticky status flag that is not cleared at the start of a frame shows up only in the next status word, one cycle after that frame's end byte. The bench therefore compares every output in every cycle, and runs frames back to back with differing flags.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int LEN_W = 16;

  typedef struct packed {
    logic [11:0]      rsvd;
    logic             promisc_only;
    logic             late_coll;
    logic             crc_bad;
    logic             too_long;
    logic [LEN_W-1:0] length;
  } rx_stat_t;

  // Saturating byte count step
  function automatic logic [LEN_W-1:0] sat_inc(input logic [LEN_W-1:0] v, input logic inc);
    if (inc && v != {LEN_W{1'b1}}) return v + LEN_W'(1);
    return v;
  endfunction

  function automatic logic [31:0] pack_stat(input logic [LEN_W-1:0] len, input logic lng,
                                            input logic crc, input logic late, input logic pmo);
    rx_stat_t s;
    s.rsvd = '0;
    s.promisc_only = pmo;
    s.late_coll = late;
    s.crc_bad = crc;
    s.too_long = lng;
    s.length = len;
    return s;
  endfunction
endpackage

// File: rtl/rxf_byte_counter.sv
module rxf_byte_counter
  import rxf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byte_vld,
  input  logic             byte_sof,
  input  logic             byte_eof,
  output logic             start,
  output logic             active,
  output logic             frame_end,
  output logic [LEN_W-1:0] cnt_now
);
  logic             in_q;
  logic [LEN_W-1:0] cnt_q;

  assign start     = byte_vld & byte_sof;
  assign active    = start | in_q;
  assign frame_end = active & byte_vld & byte_eof;
  assign cnt_now   = start ? LEN_W'(1) : sat_inc(cnt_q, byte_vld);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      if (frame_end)  in_q <= 1'b0;
      else if (start) in_q <= 1'b1;
      if (active) cnt_q <= cnt_now;
    end
  end
endmodule

// File: rtl/rxf_addr_check.sv
module rxf_addr_check
  import rxf_pkg::*;
#(
  parameter int ADDR_BYTES = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic                    active,
  input  logic                    byte_vld,
  input  logic [LEN_W-1:0]        cnt_now,
  input  logic [7:0]              byte_data,
  input  logic [8*ADDR_BYTES-1:0] station_addr,
  output logic                    addr_eval,
  output logic                    addr_hit,
  output logic                    bcast_hit
);
  logic [ADDR_BYTES-1:0] byte_eq;
  logic sel_eq, in_field, ex_q, bc_q, ex_base, bc_base;

  for (genvar k = 0; k < ADDR_BYTES; k++) begin : g_cmp
    assign byte_eq[k] = (byte_data == station_addr[8*k +: 8]);
  end

  always_comb begin
    sel_eq = 1'b0;
    for (int k = 0; k < ADDR_BYTES; k++)
      if (cnt_now == LEN_W'(k + 1)) sel_eq = byte_eq[k];
  end

  assign in_field  = active & byte_vld & (cnt_now <= LEN_W'(ADDR_BYTES));
  assign ex_base   = start ? 1'b1 : ex_q;
  assign bc_base   = start ? 1'b1 : bc_q;
  assign addr_hit  = in_field ? (ex_base & sel_eq) : ex_base;
  assign bcast_hit = in_field ? (bc_base & (byte_data == 8'hFF)) : bc_base;
  assign addr_eval = active & byte_vld & (cnt_now == LEN_W'(ADDR_BYTES));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ex_q <= 1'b0;
      bc_q <= 1'b0;
    end else if (active) begin
      ex_q <= addr_hit;
      bc_q <= bcast_hit;
    end
  end
endmodule

// File: rtl/rxf_status.sv
module rxf_status
  import rxf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             active,
  input  logic             byte_vld,
  input  logic             frame_end,
  input  logic             commit,
  input  logic [LEN_W-1:0] cnt_now,
  input  logic [LEN_W-1:0] max_len,
  input  logic             late_evt,
  input  logic             pmo_evt,
  input  logic             crc_err,
  output logic             long_evt,
  output logic             stat_wr,
  output logic [31:0]      stat_word,
  output logic             babr_irq
);
  logic long_q, late_q, pmo_q;
  logic long_nx, late_nx, pmo_nx, over;

  assign over     = active & byte_vld & (cnt_now > max_len);
  assign long_evt = over & ~(start ? 1'b0 : long_q);
  assign long_nx  = (start ? 1'b0 : long_q) | over;
  assign late_nx  = (start ? 1'b0 : late_q) | late_evt;
  assign pmo_nx   = (start ? 1'b0 : pmo_q) | pmo_evt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      long_q    <= 1'b0;
      late_q    <= 1'b0;
      pmo_q     <= 1'b0;
      stat_wr   <= 1'b0;
      stat_word <= '0;
      babr_irq  <= 1'b0;
    end else begin
      if (active) begin
        long_q <= long_nx;
        late_q <= late_nx;
        pmo_q  <= pmo_nx;
      end
      babr_irq <= long_evt;
      stat_wr  <= frame_end & commit;
      if (frame_end & commit)
        stat_word <= pack_stat(cnt_now, long_nx, crc_err, late_nx, pmo_nx);
    end
  end
endmodule

// File: rtl/rx_accept_filter.sv
module rx_accept_filter
  import rxf_pkg::*;
#(
  parameter int WINDOW     = 64,
  parameter int ADDR_BYTES = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    byte_vld,
  input  logic                    byte_sof,
  input  logic                    byte_eof,
  input  logic [7:0]              byte_data,
  input  logic                    coll,
  input  logic                    crc_err,
  input  logic [8*ADDR_BYTES-1:0] station_addr,
  input  logic [LEN_W-1:0]        max_len,
  input  logic                    promisc,
  input  logic                    rfint_en,
  output logic                    fifo_accept,
  output logic                    fifo_reject,
  output logic                    stat_wr,
  output logic [31:0]             stat_word,
  output logic                    babr_irq,
  output logic                    rfint_irq
);
  localparam logic [LEN_W-1:0] WIN = LEN_W'(WINDOW);

  logic start, active, frame_end;
  logic [LEN_W-1:0] cnt_now;
  logic addr_eval, addr_hit, bcast_hit;
  logic dec_q, acc_q, dec_base, acc_base;
  logic in_window, early_coll, miss_rej, runt_end, rej_now, acc_now;
  logic commit, late_evt, pmo_evt, long_evt;

  rxf_byte_counter u_cnt (
    .clk, .rst_n, .byte_vld, .byte_sof, .byte_eof,
    .start, .active, .frame_end, .cnt_now
  );

  rxf_addr_check #(.ADDR_BYTES(ADDR_BYTES)) u_addr (
    .clk, .rst_n, .start, .active, .byte_vld, .cnt_now, .byte_data,
    .station_addr, .addr_eval, .addr_hit, .bcast_hit
  );

  // Decision logic: one verdict per frame
  assign dec_base   = start ? 1'b0 : dec_q;
  assign acc_base   = start ? 1'b0 : acc_q;
  assign in_window  = cnt_now < WIN;
  assign early_coll = active & coll & in_window;
  assign miss_rej   = addr_eval & ~(addr_hit | bcast_hit | promisc);
  assign runt_end   = frame_end & in_window;
  assign rej_now    = ~dec_base & (early_coll | miss_rej | runt_end);
  assign acc_now    = ~dec_base & ~rej_now & active & byte_vld & (cnt_now == WIN);
  assign commit     = acc_base | acc_now;
  assign late_evt   = active & coll & ~in_window;
  assign pmo_evt    = addr_eval & ~(addr_hit | bcast_hit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_q       <= 1'b0;
      acc_q       <= 1'b0;
      fifo_accept <= 1'b0;
      fifo_reject <= 1'b0;
      rfint_irq   <= 1'b0;
    end else begin
      if (active) begin
        dec_q <= dec_base | rej_now | acc_now;
        acc_q <= commit;
      end
      fifo_accept <= acc_now;
      fifo_reject <= rej_now;
      rfint_irq   <= frame_end & commit & rfint_en;
    end
  end

  rxf_status u_stat (
    .clk, .rst_n, .start, .active, .byte_vld, .frame_end, .commit, .cnt_now,
    .max_len, .late_evt, .pmo_evt, .crc_err, .long_evt, .stat_wr, .stat_word,
    .babr_irq
  );
endmodule

// File: rtl/rxf_checks.sv
module rxf_checks
  import rxf_pkg::*;
#(
  parameter int WINDOW = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fifo_accept,
  input logic             fifo_reject,
  input logic             stat_wr,
  input logic [31:0]      stat_word,
  input logic             babr_irq,
  input logic             rfint_irq,
  input logic [LEN_W-1:0] cnt_now,
  input logic [LEN_W-1:0] max_len,
  input logic             long_evt
);
  // R7
  one_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(fifo_accept && fifo_reject));
  // R3
  accept_at_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_accept |-> $past(cnt_now) == LEN_W'(WINDOW));
  // R5
  reject_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_reject |-> $past(cnt_now) < LEN_W'(WINDOW));
  // R9
  babr_over_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    babr_irq |-> $past(cnt_now) > $past(max_len));
  // R9
  babr_follows_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    long_evt |=> babr_irq);
  // R11
  rfint_with_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rfint_irq |-> stat_wr);
  // R10
  stat_rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wr |-> stat_word[31:20] == 12'd0);
  // R10
  stat_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wr |-> stat_word[15:0] == $past(cnt_now));
endmodule

bind rx_accept_filter rxf_checks #(.WINDOW(WINDOW)) u_chk (
  .clk(clk), .rst_n(rst_n), .fifo_accept(fifo_accept), .fifo_reject(fifo_reject),
  .stat_wr(stat_wr), .stat_word(stat_word), .babr_irq(babr_irq), .rfint_irq(rfint_irq),
  .cnt_now(cnt_now), .max_len(max_len), .long_evt(long_evt)
);

// File: tb/rx_accept_filter_tb.sv
module rx_accept_filter_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic byte_vld = 0, byte_sof = 0, byte_eof = 0, coll = 0, crc_err = 0;
  logic [7:0] byte_data = 0;
  logic [47:0] station_addr = 48'h0A1B2C3D4E5F;
  logic [15:0] max_len = 16'd1518;
  logic promisc = 0, rfint_en = 1;
  logic fifo_accept, fifo_reject, stat_wr, babr_irq, rfint_irq;
  logic [31:0] stat_word;

  int checks = 0, failures = 0;

  // reference model state
  int m_in = 0, m_cnt = 0;
  bit m_dec = 0, m_acc = 0, m_ex = 0, m_bc = 0, m_lng = 0, m_late = 0, m_pmo = 0;
  bit e_acc = 0, e_rej = 0, e_wr = 0, e_babr = 0, e_rf = 0;
  logic [31:0] e_word = 0;

  always #5 clk = ~clk;

  rx_accept_filter u_dut (
    .clk, .rst_n, .byte_vld, .byte_sof, .byte_eof, .byte_data, .coll, .crc_err,
    .station_addr, .max_len, .promisc, .rfint_en, .fifo_accept, .fifo_reject,
    .stat_wr, .stat_word, .babr_irq, .rfint_irq
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk(fifo_accept === e_acc, "R3 fifo_accept", 32'(fifo_accept), 32'(e_acc));
    chk(fifo_reject === e_rej, "R5/R6 fifo_reject", 32'(fifo_reject), 32'(e_rej));
    chk(stat_wr === e_wr, "R10 stat_wr", 32'(stat_wr), 32'(e_wr));
    chk(babr_irq === e_babr, "R9 babr_irq", 32'(babr_irq), 32'(e_babr));
    chk(rfint_irq === e_rf, "R11 rfint_irq", 32'(rfint_irq), 32'(e_rf));
    if (e_wr) chk(stat_word === e_word, "R10 stat_word", stat_word, e_word);
  endtask

  // Behavioural next-output prediction from the inputs of this cycle
  task automatic model();
    bit rej;
    logic [7:0] sab;
    e_acc = 0; e_rej = 0; e_wr = 0; e_babr = 0; e_rf = 0;
    if (byte_vld && byte_sof) begin
      m_in = 1; m_cnt = 0; m_dec = 0; m_acc = 0; m_ex = 1; m_bc = 1;
      m_lng = 0; m_late = 0; m_pmo = 0;
    end
    if (m_in == 0) return;
    if (byte_vld) begin
      if (m_cnt < 65535) m_cnt++;
      if (m_cnt <= 6) begin
        sab = station_addr[8*(m_cnt-1) +: 8];
        m_ex = m_ex && (byte_data == sab);
        m_bc = m_bc && (byte_data == 8'hFF);
      end
    end
    rej = 0;
    if (byte_vld && m_cnt == 6 && !(m_ex || m_bc)) begin
      m_pmo = 1;
      if (!promisc) rej = 1;
    end
    if (coll && m_cnt < 64) rej = 1;
    if (coll && m_cnt >= 64) m_late = 1;
    if (byte_vld && byte_eof && m_cnt < 64) rej = 1;
    if (!m_dec && rej) begin
      e_rej = 1; m_dec = 1;
    end else if (!m_dec && byte_vld && m_cnt == 64) begin
      e_acc = 1; m_dec = 1; m_acc = 1;
    end
    if (byte_vld && m_cnt > max_len && !m_lng) begin
      m_lng = 1; e_babr = 1;
    end
    if (byte_vld && byte_eof) begin
      if (m_acc) begin
        e_wr = 1;
        e_rf = rfint_en;
        e_word = {12'd0, m_pmo, m_late, crc_err, m_lng, 16'(m_cnt)};
      end
      m_in = 0;
    end
  endtask

  task automatic tick(input bit v, input bit s, input bit e, input logic [7:0] d,
                      input bit c, input bit crc);
    byte_vld = v; byte_sof = s; byte_eof = e; byte_data = d; coll = c; crc_err = crc;
    model();
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  // kind: 0 station, 1 broadcast; badpos: destination byte to corrupt (0 none)
  task automatic send(input int len, input int kind, input int badpos, input int coll_at,
                      input bit crc, input bit gaps);
    logic [7:0] d;
    for (int i = 1; i <= len; i++) begin
      if (gaps && i % 7 == 0) tick(0, 0, 0, 8'h00, 0, 0);
      if (i <= 6) begin
        d = (kind == 1) ? 8'hFF : station_addr[8*(i-1) +: 8];
        if (i == badpos) d = d ^ 8'h01;
      end else d = 8'(i) ^ 8'h5A;
      tick(1, i == 1, i == len, d, i == coll_at, (i == len) && crc);
    end
    tick(0, 0, 0, 8'h00, 0, 0);
    tick(0, 0, 0, 8'h00, 0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL R1 watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs quiet under reset
    chk({fifo_accept, fifo_reject, stat_wr, babr_irq, rfint_irq} === 5'b0 && stat_word === 32'd0,
        "R1 reset outputs", {27'd0, fifo_accept, fifo_reject, stat_wr, babr_irq, rfint_irq}, 32'd0);
    rst_n = 1'b1;
    tick(0, 0, 0, 8'h00, 0, 0);
    // R1 first cycle after reset checked by compare in tick
    tick(0, 0, 1, 8'h00, 1, 0);             // R5: coll outside a frame has no effect
    send(70, 0, 0, 0, 0, 0);                // R2 R3 R10: station match, accepted
    send(64, 1, 0, 0, 1, 1);                // R2 R3 R10: broadcast, end exactly at byte 64, crc flag
    send(80, 0, 6, 0, 0, 0);                // R4: last address byte wrong
    send(80, 0, 1, 0, 0, 1);                // R4: first address byte wrong
    send(80, 1, 3, 0, 0, 0);                // R2 R4: broken broadcast
    promisc = 1;
    send(66, 0, 2, 0, 0, 0);                // R2 R10: promiscuous admit sets bit 19
    promisc = 0;
    send(90, 0, 0, 20, 0, 0);               // R5: early collision
    send(90, 0, 0, 63, 0, 0);               // R5: collision at byte 63
    send(90, 0, 0, 64, 0, 0);               // R8: collision at byte 64 is late
    send(100, 0, 0, 85, 1, 1);              // R8: late collision
    send(30, 0, 0, 0, 0, 0);                // R6: runt
    send(63, 0, 0, 0, 0, 0);                // R6: one short of the window
    send(1, 0, 0, 0, 0, 0);                 // R6: single byte frame
    send(3, 0, 0, 0, 0, 0);                 // R6: ends inside address field
    send(8, 0, 2, 0, 0, 0);                 // R7: address miss then runt end, one reject only
    max_len = 16'd100;
    send(120, 0, 0, 0, 0, 0);               // R9: long frame, not truncated
    send(101, 1, 0, 0, 0, 1);               // R9: exceeds by one
    send(100, 0, 0, 0, 0, 0);               // R9: at limit, no babble
    send(70, 0, 4, 0, 0, 0);                // R9: short frame, not long
    rfint_en = 0;
    send(70, 0, 0, 0, 0, 0);                // R11: interrupt masked
    rfint_en = 1;
    send(70, 0, 0, 0, 1, 0);                // R10: fresh flags after earlier frames
    // back-to-back frames, no idle gap (R7)
    for (int f = 0; f < 3; f++)
      for (int i = 1; i <= 65; i++)
        tick(1, i == 1, i == 65, (i <= 6) ? station_addr[8*(i-1) +: 8] : 8'(i), 0, 0);
    tick(0, 0, 0, 8'h00, 0, 0);
    tick(0, 0, 0, 8'h00, 0, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule